// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is the counting core of a real-time clock. It keeps seconds, minutes, hours, day of month, month and a two-digit year, each as a packed-BCD byte, and advances the whole set by one second after every `TICKS_PER_SEC` pulses of an incoming base tick. The base tick comes from an external prescaler; with `TICKS_PER_SEC = 1` it is a plain one-second strobe. Day rollover follows the month length, and February gains its 29th day in every year whose two-digit value is a multiple of four, which holds for the whole 2000 to 2099 span the year byte covers.

Software reaches the block through a single-cycle register port: a write strobe with address and data, and a combinational read of the addressed register. Alarm matching is done field by field. Each of the six time fields has its own match enable, and a field whose enable is clear is ignored. A separate global enable gates the whole comparison. The comparison runs once per second step, against the freshly updated time. A hit gives a one-cycle pulse and latches a pending bit, which drives the interrupt output until software clears it by writing a 1.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the control register reads 0x00, the time reads 00:00:00 on day 0x01, month 0x01, year 0x00, and the alarm registers and the pending bit read 0.
- R2: Address map: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 alarm control, 8 to 13 alarm values in the same field order, 14 pending. Every field is packed BCD. A write to addresses 1 to 13 takes effect only while control bit 0 (run) is 1 and is ignored otherwise. Control and pending writes are always accepted.
- R3: With control = 0x01, seconds advance by one for every `TICKS_PER_SEC` base ticks. Setting control bit 1 (test hold) or bit 2 (phase reset), or clearing run, stops counting.
- R4: Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R5: The day wraps to 0x01 after 0x28 or 0x29 in February (0x29 when the year value is divisible by 4, 00 included), after 0x30 in April, June, September and November, and after 0x31 otherwise. The wrap carries into the month.
- R6: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R7: A write to any time register restarts the sub-second phase. The next step then comes a full `TICKS_PER_SEC` base ticks after the write.
- R8: Alarm control bits 0 to 5 enable matching of seconds, minutes, hours, day, month and year, and bit 6 is the global enable. In the cycle after a second step, `alarmHit` is 1 for one cycle if the global enable is set and every enabled field equals the time. A disabled field with a different value does not block the match. In the next cycle the pending bit (address 14, bit 0) and `irqOut` are 1.
- R9: Writing 1 to pending bit 0 clears it. Writing 0 leaves it set. A hit in the same cycle as a clear wins.
- R10: While control bit 2 is set, the sub-second phase is held at zero, so after the bit is cleared a full `TICKS_PER_SEC` ticks pass before the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseTick | input | 1 | Sub-second tick from the prescaler |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |
| alarmHit | output | 1 | One-cycle alarm match pulse |
| irqOut | output | 1 | Alarm pending level |

## Verification
The bench builds the core with `TICKS_PER_SEC = 2`, so one second costs two base ticks. That keeps long random runs short. It also leaves a mid-second phase that can be observed when a time write or a phase reset lands between ticks. Rollovers of the day, month and year are reached by preloading times just before a boundary, not by counting up to them. Random preloads bias toward 59 seconds, 59 minutes, 23 hours and the last day of the month, so carry chains are exercised often.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_FIELDS = 6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_TIME0  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_ALMCTL = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_ALM0   = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 4'd14;

  typedef struct packed {
    logic secStep;   // advance time by one second
    logic checkNow;  // compare alarm against updated time
    logic timeWr;    // accepted write to a time field
    logic alarmWr;   // accepted write to alarm control or value
    logic pendClr;   // write-one-to-clear of pending bit
  } rtcStrobes_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output rtcStrobes_t       strb,
  output logic [2:0]        ctrlBits
);
  localparam int PHASE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(TICKS_PER_SEC - 1);

  logic [2:0]         ctrlQ;   // [0] run, [1] test hold, [2] phase reset
  logic [PHASE_W-1:0] phaseQ;
  logic               checkQ;
  logic               running, timeSel, alarmSel;

  always_comb begin
    running       = ctrlQ[0] & ~ctrlQ[1] & ~ctrlQ[2];
    timeSel       = (addr >= ADDR_TIME0) && (addr < ADDR_ALMCTL);
    alarmSel      = (addr >= ADDR_ALMCTL) && (addr < ADDR_PEND);
    strb.timeWr   = wrEn & ctrlQ[0] & timeSel;
    strb.alarmWr  = wrEn & ctrlQ[0] & alarmSel;
    strb.pendClr  = wrEn & (addr == ADDR_PEND) & wrData[0];
    strb.secStep  = running & baseTick & (phaseQ == PHASE_LAST) & ~strb.timeWr;
    strb.checkNow = checkQ;
  end

  assign ctrlBits = ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      phaseQ <= '0;
      checkQ <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_CTRL) ctrlQ <= wrData[2:0];
      if (ctrlQ[2] || strb.timeWr) phaseQ <= '0;
      else if (running && baseTick)
        phaseQ <= (phaseQ == PHASE_LAST) ? '0 : phaseQ + 1'b1;
      checkQ <= strb.secStep;
    end
  end

  // R7: a time write restarts the sub-second phase
  p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.timeWr |=> phaseQ == '0);
  // R10: phase reset bit pins the phase at zero
  p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[2] |=> phaseQ == '0);
  // R3: test hold freezes the phase
  p_test_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[1] && !ctrlQ[2] && !strb.timeWr && !(wrEn && addr == ADDR_CTRL))
      |=> phaseQ == $past(phaseQ));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strb,
  input  logic [2:0]        ctrlBits,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              alarmHit,
  output logic              pendQ
);
  logic [7:0] timeQ [NUM_FIELDS];
  logic [7:0] nextT [NUM_FIELDS];
  logic [7:0] almQ  [NUM_FIELDS];
  logic [6:0] almCtlQ;
  logic [NUM_FIELDS-1:0] fieldOk;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic [2:0] timeIdx, almIdx;

  assign timeIdx = addr[2:0] - 3'd1;
  assign almIdx  = addr[2:0];

  always_comb begin
    secWrap  = timeQ[0] >= 8'h59;
    minWrap  = timeQ[1] >= 8'h59;
    hourWrap = timeQ[2] >= 8'h23;
    dayWrap  = timeQ[3] >= lastDay(timeQ[4], timeQ[5]);
    monWrap  = timeQ[4] >= 8'h12;
    for (int i = 0; i < NUM_FIELDS; i++) nextT[i] = timeQ[i];
    nextT[0] = secWrap ? 8'h00 : bcdInc(timeQ[0]);
    if (secWrap) begin
      nextT[1] = minWrap ? 8'h00 : bcdInc(timeQ[1]);
      if (minWrap) begin
        nextT[2] = hourWrap ? 8'h00 : bcdInc(timeQ[2]);
        if (hourWrap) begin
          nextT[3] = dayWrap ? 8'h01 : bcdInc(timeQ[3]);
          if (dayWrap) begin
            nextT[4] = monWrap ? 8'h01 : bcdInc(timeQ[4]);
            if (monWrap) nextT[5] = (timeQ[5] >= 8'h99) ? 8'h00 : bcdInc(timeQ[5]);
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_match
    assign fieldOk[g] = ~almCtlQ[g] | (almQ[g] == timeQ[g]);
  end

  assign alarmHit = strb.checkNow & almCtlQ[6] & (&fieldOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        timeQ[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        almQ[i]  <= 8'h00;
      end
      almCtlQ <= '0;
      pendQ   <= 1'b0;
    end else begin
      if (strb.timeWr) timeQ[timeIdx] <= wrData;
      else if (strb.secStep) timeQ <= nextT;
      if (strb.alarmWr) begin
        if (addr == ADDR_ALMCTL) almCtlQ <= wrData[6:0];
        else almQ[almIdx] <= wrData;
      end
      if (alarmHit) pendQ <= 1'b1;
      else if (strb.pendClr) pendQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (addr == ADDR_CTRL) rdData = {5'b0, ctrlBits};
    else if (addr < ADDR_ALMCTL) rdData = timeQ[timeIdx];
    else if (addr == ADDR_ALMCTL) rdData = {1'b0, almCtlQ};
    else if (addr < ADDR_PEND) rdData = almQ[almIdx];
    else if (addr == ADDR_PEND) rdData = {7'b0, pendQ};
  end

  // R8: a hit always lands in the pending bit
  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> pendQ);
  // R9: a clear without a competing hit empties the pending bit
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pendClr && !alarmHit) |=> !pendQ);
  // R3: every step changes the seconds field
  p_sec_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.secStep |=> timeQ[0] != $past(timeQ[0]));
  // R5: a step never produces day zero
  p_day_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.secStep && timeQ[3] != 8'h00) |=> timeQ[3] != 8'h00);
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       alarmHit,
  output logic       irqOut
);
  rtcStrobes_t strb;
  logic [2:0]  ctrlBits;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) ctrl_i (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .strb(strb), .ctrlBits(ctrlBits)
  );

  rtc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlBits(ctrlBits),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .alarmHit(alarmHit), .pendQ(irqOut)
  );
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  localparam int TPS = 2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic alarmHit, irqOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .alarmHit(alarmHit), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  function automatic int toBcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 4'(a);
    #1;
    d = int'(rdData);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    baseTick = 1'b1;
    repeat (n) @(negedge clk);
    baseTick = 1'b0;
  endtask

  task automatic setTime(input int t[6]);
    for (int i = 0; i < 6; i++) wr(i + 1, toBcd(t[i]));
  endtask

  task automatic expectTime(input string tag, input int t[6]);
    int v;
    for (int i = 0; i < 6; i++) begin
      rd(i + 1, v);
      chk(tag, v, toBcd(t[i]));
    end
  endtask

  task automatic stepModel(inout int t[6]);
    t[0]++;
    if (t[0] == 60) begin
      t[0] = 0; t[1]++;
      if (t[1] == 60) begin
        t[1] = 0; t[2]++;
        if (t[2] == 24) begin
          t[2] = 0; t[3]++;
          if (t[3] > dim(t[4], t[5])) begin
            t[3] = 1; t[4]++;
            if (t[4] == 13) begin
              t[4] = 1; t[5] = (t[5] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic rollCase(input string tag, input int t[6]);
    int e[6];
    e = t;
    setTime(t);
    tick(TPS);
    stepModel(e);
    expectTime(tag, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int t[6];
    int e[6];
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    t = '{0, 0, 0, 1, 1, 0};
    expectTime("R1 time", t);
    rd(7, v); chk("R1 almctl", v, 0);
    rd(8, v); chk("R1 almsec", v, 0);
    rd(14, v); chk("R1 pend", v, 0);
    chk("R1 irq", int'(irqOut), 0);

    // R2 writes ignored while run is clear
    wr(1, 8'h33);
    rd(1, v); chk("R2 ignored sec", v, 0);
    wr(9, 8'h12);
    rd(9, v); chk("R2 ignored alm", v, 0);
    wr(0, 1);
    t = '{45, 7, 13, 22, 9, 37};
    setTime(t);
    expectTime("R2 readback", t);

    // R3 counting and hold
    tick(TPS);
    e = t; stepModel(e);
    expectTime("R3 step", e);
    tick(3 * TPS);
    for (int k = 0; k < 3; k++) stepModel(e);
    expectTime("R3 three steps", e);
    wr(0, 3);
    tick(4 * TPS);
    rd(1, v); chk("R3 test hold", v, toBcd(e[0]));
    wr(0, 0);
    tick(4 * TPS);
    rd(1, v); chk("R3 run clear", v, toBcd(e[0]));
    wr(0, 1);

    // R7 time write restarts phase
    wr(1, 8'h10);
    tick(1);
    wr(1, 8'h20);
    tick(1);
    rd(1, v); chk("R7 no early step", v, 8'h20);
    tick(1);
    rd(1, v); chk("R7 full second", v, 8'h21);

    // R10 phase reset bit
    tick(1);
    wr(0, 5);
    tick(3);
    rd(1, v); chk("R10 held", v, 8'h21);
    wr(0, 1);
    tick(1);
    rd(1, v); chk("R10 no step after release", v, 8'h21);
    tick(1);
    rd(1, v); chk("R10 step", v, 8'h22);

    // R4 / R5 / R6 directed boundaries
    rollCase("R4 minute carry", '{59, 14, 3, 5, 5, 10});
    rollCase("R4 hour carry", '{59, 59, 9, 5, 5, 10});
    rollCase("R4 day carry", '{59, 59, 23, 5, 5, 10});
    rollCase("R5 leap feb", '{59, 59, 23, 28, 2, 24});
    rollCase("R5 feb29 end", '{59, 59, 23, 29, 2, 24});
    rollCase("R5 plain feb", '{59, 59, 23, 28, 2, 23});
    rollCase("R5 year00 leap", '{59, 59, 23, 28, 2, 0});
    rollCase("R5 april", '{59, 59, 23, 30, 4, 51});
    rollCase("R5 january", '{59, 59, 23, 30, 1, 51});
    rollCase("R6 new year", '{59, 59, 23, 31, 12, 41});
    rollCase("R6 year wrap", '{59, 59, 23, 31, 12, 99});

    // R4 R5 R6 random preloads
    for (int n = 0; n < 40; n++) begin
      int r[6];
      r[5] = $urandom_range(99);
      r[4] = $urandom_range(12, 1);
      r[3] = ($urandom_range(1) == 1) ? dim(r[4], r[5]) : $urandom_range(dim(r[4], r[5]), 1);
      r[2] = ($urandom_range(1) == 1) ? 23 : $urandom_range(23);
      r[1] = ($urandom_range(1) == 1) ? 59 : $urandom_range(59);
      r[0] = ($urandom_range(2) != 0) ? 59 : $urandom_range(59);
      rollCase("R5 random", r);
    end

    // R8 alarm match
    t = '{29, 20, 10, 3, 3, 30};
    setTime(t);
    wr(8, 8'h30); wr(9, 8'h20); wr(10, 8'h05);
    wr(7, 8'h43);
    tick(TPS);
    chk("R8 hit pulse", int'(alarmHit), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(alarmHit), 0);
    rd(14, v); chk("R8 pending", v, 1);
    chk("R8 irq", int'(irqOut), 1);

    // R9 write-one clear
    wr(14, 0);
    rd(14, v); chk("R9 zero keeps", v, 1);
    wr(14, 1);
    rd(14, v); chk("R9 cleared", v, 0);
    chk("R9 irq low", int'(irqOut), 0);

    // R8 enabled mismatch blocks, global disable blocks
    setTime(t);
    wr(7, 8'h47);
    tick(TPS);
    chk("R8 hour mismatch", int'(alarmHit), 0);
    @(negedge clk);
    rd(14, v); chk("R8 no pend mismatch", v, 0);
    setTime(t);
    wr(7, 8'h03);
    tick(TPS);
    chk("R8 global off", int'(alarmHit), 0);
    @(negedge clk);
    rd(14, v); chk("R8 no pend global", v, 0);
    wr(10, 8'h10);
    setTime(t);
    wr(7, 8'h47);
    tick(TPS);
    chk("R8 hour match", int'(alarmHit), 1);
    @(negedge clk);
    rd(14, v); chk("R8 pend hour", v, 1);
    wr(14, 1);

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule